// File: doc/BRIEF.md
# Block Floating-Point Growth Detector

This block watches four holding registers of a complex multiply-accumulate datapath: the real and imaginary accumulator holding registers, and the real and imaginary product holding registers. For each register it works out how many bits the stored value has grown beyond that register's nominal signed range. It then reports the largest of the four results as a 2-bit growth code. Downstream logic uses this code to decide how far to shift the data before it reaches a narrower output bus.

A strobe marks each cycle in which the holding registers take new contents. A peak control selects between two modes. In follow mode the code shows the growth of the most recently loaded contents. In peak mode the code keeps the largest growth seen since the mode was entered, and that starting value includes the contents already held at entry. The block does not accumulate and does not rescale any data.

Top module: `growth_detector`

## Requirements
- R1: An accumulator holding register is 20 bits wide, two's complement, with its sign at bit 19. Its growth is judged from bits 15 to 18. The growth is the smallest g in 0..2 for which the value fits in 16+g signed bits. If no such g exists, the growth is 3.
- R2: A product holding register is 35 bits wide, two's complement, with its sign at bit 34. Its growth is judged from bits 30 to 33. The growth is the smallest g in 0..2 for which the value fits in 31+g signed bits. If no such g exists, the growth is 3.
- R3: The current growth is the maximum of the growths of all four registers.
- R4: The output code is the growth as an unsigned 2-bit number, so the values run from 0 to 3. With peak low, a load strobe seen at a rising clock edge makes the code equal the current growth of that cycle's inputs from that edge on.
- R5: With peak low in both the present and the previous cycle, a cycle without a load leaves the code unchanged, whatever the register inputs do.
- R6: With peak high, each load sets the code to the larger of the code and the new current growth. The code never decreases while peak stays high. A cycle without a load leaves the code unchanged.
- R7: When peak is raised, tracking starts from the growth of the contents loaded before the rise. Later loads with smaller growth do not lower the code.
- R8: At the first edge with peak low after a peak period, the tracked maximum is discarded. The code becomes the growth of the most recent load, or of the load in that same cycle if there is one.
- R9: A synchronous active-high reset sets the code, and the stored growth of the last load, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_re_i | input | 20 | Real accumulator holding register contents |
| acc_im_i | input | 20 | Imaginary accumulator holding register contents |
| prd_re_i | input | 35 | Real product holding register contents |
| prd_im_i | input | 35 | Imaginary product holding register contents |
| load_i | input | 1 | Holding registers took new contents this cycle |
| peak_i | input | 1 | 1 = track maximum growth, 0 = follow latest load |
| det_o | output | 2 | Registered growth code |

## Verification
The grading is swept per register over every growth class. Each class is driven with its largest positive value, its most negative value and an interior value, so that off-by-one errors at the class edges and errors in handling the sign are told apart. A sweep over all 256 combinations of class across the four registers checks the selection of the maximum, and shows whether the real/imaginary pair or the accumulator/product pair is ever ignored. Pseudo-random runs that toggle peak and load, together with directed sequences for entering and leaving peak mode, separate a plain follower from a true maximum tracker. The same runs show whether the contents held at entry are included and whether the tracked maximum is discarded when peak drops.

// File: rtl/gd_pkg.sv
package gd_pkg;

    localparam int CODE_W    = 2;
    localparam int GRADE_MAX = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] grade_t;

    // Decoded relation between present and previous peak control.
    typedef enum logic [1:0] {
        MODE_FOLLOW = 2'b00,
        MODE_ENTER  = 2'b01,
        MODE_LEAVE  = 2'b10,
        MODE_TRACK  = 2'b11
    } track_mode_t;

    typedef struct packed {
        grade_t last;   // growth of the most recently loaded contents
        grade_t shown;  // value presented on the output
    } track_state_t;

    function automatic grade_t grade_larger(input grade_t a, input grade_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic track_mode_t mode_of(input logic peak_now, input logic peak_prev);
        return track_mode_t'({peak_prev, peak_now});
    endfunction

endpackage

// File: rtl/gd_field_grade.sv
module gd_field_grade
    import gd_pkg::*;
#(
    parameter int REG_W    = 20,
    parameter int FIELD_LO = 15,
    parameter int FIELD_W  = 4
) (
    input  logic [REG_W-1:0] reg_i,
    output grade_t           grade_o
);
    localparam int SIGN_POS = REG_W - 1;
    localparam int NOM_W    = FIELD_LO + 1;

    logic sign;
    assign sign = reg_i[SIGN_POS];

    always_comb begin
        grade_o = '0;
        for (int k = 0; k < FIELD_W; k++) begin
            if (reg_i[FIELD_LO + k] != sign) begin
                grade_o = (k + 1 > GRADE_MAX) ? grade_t'(GRADE_MAX) : grade_t'(k + 1);
            end
        end
    end

    // R1 / R2: a value inside the nominal signed range reports no growth
    logic signed [REG_W-1:0] shifted;
    assign shifted = $signed(reg_i) >>> (NOM_W - 1);

    always_comb begin
        if (shifted == '0 || shifted == '1) begin
            p_nominal_zero_r1: assert (grade_o == '0);
        end
    end

endmodule

// File: rtl/gd_max_tree.sv
module gd_max_tree
    import gd_pkg::*;
#(
    parameter int N = 4
) (
    input  grade_t grades_i [N],
    output grade_t max_o
);
    always_comb begin
        max_o = '0;
        for (int i = 0; i < N; i++) begin
            max_o = grade_larger(max_o, grades_i[i]);
        end
    end

    // R3: the maximum bounds every input and equals at least one of them
    always_comb begin
        int hits;
        hits = 0;
        for (int i = 0; i < N; i++) begin
            p_max_bounds_r3: assert (grades_i[i] <= max_o);
            if (grades_i[i] == max_o) hits++;
        end
        p_max_member_r3: assert (hits > 0);
    end

endmodule

// File: rtl/gd_peak_track.sv
module gd_peak_track
    import gd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  logic   peak_i,
    input  grade_t cur_i,
    output grade_t code_o
);
    track_state_t st_q, st_d;
    logic         peak_q;
    track_mode_t  mode;
    grade_t       fresh;

    assign mode  = mode_of(peak_i, peak_q);
    assign fresh = load_i ? cur_i : st_q.last;

    always_comb begin
        st_d      = st_q;
        st_d.last = fresh;
        unique case (mode)
            MODE_ENTER,
            MODE_TRACK:  st_d.shown = load_i ? grade_larger(st_q.shown, cur_i) : st_q.shown;
            MODE_LEAVE,
            MODE_FOLLOW: st_d.shown = fresh;
            default:     st_d.shown = fresh;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            peak_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            peak_q <= peak_i;
        end
    end

    assign code_o = st_q.shown;

    p_reset_clear_r9: assert property (@(posedge clk) rst |=> code_o == '0);

    p_load_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (!peak_i && load_i) |=> code_o == $past(cur_i));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!peak_i && !load_i && $past(!peak_i)) |=> $stable(code_o));

    p_peak_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
        peak_i |=> code_o >= $past(code_o));

    p_peak_covers_load_r6: assert property (@(posedge clk) disable iff (rst)
        (peak_i && load_i) |=> code_o >= $past(cur_i));

endmodule

// File: rtl/growth_detector.sv
module growth_detector
    import gd_pkg::*;
#(
    parameter int ACC_W   = 20,
    parameter int ACC_LO  = 15,
    parameter int PRD_W   = 35,
    parameter int PRD_LO  = 30,
    parameter int FIELD_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_re_i,
    input  logic [ACC_W-1:0] acc_im_i,
    input  logic [PRD_W-1:0] prd_re_i,
    input  logic [PRD_W-1:0] prd_im_i,
    input  logic             load_i,
    input  logic             peak_i,
    output logic [1:0]       det_o
);
    localparam int PAIRS = 2;
    localparam int N_REG = 2 * PAIRS;

    logic [ACC_W-1:0] acc_regs [PAIRS];
    logic [PRD_W-1:0] prd_regs [PAIRS];
    grade_t           grades   [N_REG];
    grade_t           cur_max;
    grade_t           code;

    assign acc_regs[0] = acc_re_i;
    assign acc_regs[1] = acc_im_i;
    assign prd_regs[0] = prd_re_i;
    assign prd_regs[1] = prd_im_i;

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        gd_field_grade #(.REG_W(ACC_W), .FIELD_LO(ACC_LO), .FIELD_W(FIELD_W)) u_acc (
            .reg_i   (acc_regs[i]),
            .grade_o (grades[i])
        );
        gd_field_grade #(.REG_W(PRD_W), .FIELD_LO(PRD_LO), .FIELD_W(FIELD_W)) u_prd (
            .reg_i   (prd_regs[i]),
            .grade_o (grades[PAIRS + i])
        );
    end

    gd_max_tree #(.N(N_REG)) u_max (
        .grades_i (grades),
        .max_o    (cur_max)
    );

    gd_peak_track u_track (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .peak_i (peak_i),
        .cur_i  (cur_max),
        .code_o (code)
    );

    assign det_o = code;

endmodule

// File: tb/tb_growth_detector.sv
module tb_growth_detector;

    localparam int ACC_W = 20;
    localparam int PRD_W = 35;
    localparam int ACC_N = 16;
    localparam int PRD_N = 31;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ACC_W-1:0] acc_re = '0, acc_im = '0;
    logic [PRD_W-1:0] prd_re = '0, prd_im = '0;
    logic             load = 1'b0, peak = 1'b0;
    logic [1:0]       det;

    int vectors = 0;
    int fails   = 0;
    int m_last  = 0;
    int m_shown = 0;
    logic [31:0] lfsr = 32'h1ace_b00c;

    always #10 clk = ~clk;

    growth_detector dut (
        .clk(clk), .rst(rst),
        .acc_re_i(acc_re), .acc_im_i(acc_im),
        .prd_re_i(prd_re), .prd_im_i(prd_im),
        .load_i(load), .peak_i(peak), .det_o(det)
    );

    function automatic bit fits(longint v, int n);
        longint lim;
        lim = longint'(1) <<< (n - 1);
        return (v >= -lim) && (v < lim);
    endfunction

    function automatic int growth(longint v, int nom);
        for (int g = 0; g < 3; g++) if (fits(v, nom + g)) return g;
        return 3;
    endfunction

    // pick a value of a given growth class: 0 = top positive, 1 = most negative, 2 = interior
    function automatic longint make_val(int g, int pick, int nom, int w);
        int b;
        if (g < 3) begin
            b = nom + g;
            case (pick % 3)
                0: return (longint'(1) <<< (b - 1)) - 1;
                1: return -(longint'(1) <<< (b - 1));
                default: return (g == 0) ? longint'(-5) : (longint'(1) <<< (b - 2));
            endcase
        end
        case (pick % 3)
            0: return (longint'(1) <<< (w - 1)) - 1;
            1: return -(longint'(1) <<< (w - 1));
            default: return -(longint'(1) <<< (nom + 2)) - 7;
        endcase
    endfunction

    function automatic logic [31:0] step_lfsr(logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(string tag);
        vectors++;
        if (det !== 2'(m_shown)) begin
            fails++;
            $display("FAIL %s: det=%0d expected=%0d at %0t", tag, det, m_shown, $time);
        end
    endtask

    task automatic apply(bit ld, bit pk, longint ar, longint ai, longint pr, longint pim, string tag);
        int cur;
        acc_re = ACC_W'(ar);
        acc_im = ACC_W'(ai);
        prd_re = PRD_W'(pr);
        prd_im = PRD_W'(pim);
        load = ld;
        peak = pk;
        cur = growth(ar, ACC_N);
        if (growth(ai, ACC_N) > cur) cur = growth(ai, ACC_N);
        if (growth(pr, PRD_N) > cur) cur = growth(pr, PRD_N);
        if (growth(pim, PRD_N) > cur) cur = growth(pim, PRD_N);
        if (pk) begin
            if (ld && cur > m_shown) m_shown = cur;
        end else begin
            m_shown = ld ? cur : m_last;
        end
        if (ld) m_last = cur;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R9: reset with loads pending still shows zero
        rst = 1'b1;
        load = 1'b1;
        acc_re = '1 >> 1;
        @(negedge clk);
        @(negedge clk);
        m_last = 0;
        m_shown = 0;
        check("R9 reset");
        rst = 1'b0;
        load = 1'b0;

        // R1: each accumulator register across all classes and picks
        for (int g = 0; g < 4; g++)
            for (int p = 0; p < 3; p++) begin
                apply(1, 0, make_val(g, p, ACC_N, ACC_W), 0, 0, 0, "R1 acc real");
                apply(1, 0, 0, make_val(g, p, ACC_N, ACC_W), 0, 0, "R1 acc imag");
            end

        // R2: each product register across all classes and picks
        for (int g = 0; g < 4; g++)
            for (int p = 0; p < 3; p++) begin
                apply(1, 0, 0, 0, make_val(g, p, PRD_N, PRD_W), 0, "R2 prd real");
                apply(1, 0, 0, 0, 0, make_val(g, p, PRD_N, PRD_W), "R2 prd imag");
            end

        // R3 / R4: all 256 class combinations over the four registers
        for (int c = 0; c < 256; c++) begin
            apply(1, 0,
                  make_val(c & 3, c, ACC_N, ACC_W),
                  make_val((c >> 2) & 3, c + 1, ACC_N, ACC_W),
                  make_val((c >> 4) & 3, c + 2, PRD_N, PRD_W),
                  make_val((c >> 6) & 3, c, PRD_N, PRD_W), "R3 max of four");
        end

        // R5: inputs move without a load, code must hold
        apply(1, 0, make_val(1, 0, ACC_N, ACC_W), 0, 0, 0, "R4 load");
        apply(0, 0, make_val(3, 1, ACC_N, ACC_W), 0, make_val(3, 0, PRD_N, PRD_W), 0, "R5 no load");
        apply(0, 0, 0, 0, 0, 0, "R5 no load");

        // R7: entry keeps the held growth of 2, smaller loads do not lower it
        apply(1, 0, 0, make_val(2, 1, ACC_N, ACC_W), 0, 0, "R4 load");
        apply(0, 1, 0, 0, 0, 0, "R7 peak entry");
        apply(1, 1, 5, 0, 0, 0, "R7 smaller load");
        apply(1, 1, 0, 0, make_val(3, 2, PRD_N, PRD_W), 0, "R6 larger load");
        apply(1, 1, 0, 0, 0, 0, "R6 zero load");
        // R8: leaving peak discards the maximum
        apply(0, 0, 0, 0, 0, 0, "R8 peak exit");
        apply(1, 1, make_val(1, 2, ACC_N, ACC_W), 0, 0, 0, "R7 entry with load");
        apply(1, 0, 0, 0, 0, make_val(0, 0, PRD_N, PRD_W), "R8 exit with load");

        // R6 / R8: pseudo-random mix of loads and peak toggles
        for (int i = 0; i < 800; i++) begin
            lfsr = step_lfsr(lfsr);
            if (lfsr[7:5] == 3'd0) peak = ~peak;
            apply(lfsr[0], peak,
                  make_val(int'(lfsr[9:8]), int'(lfsr[17:16]), ACC_N, ACC_W),
                  make_val(int'(lfsr[11:10]), int'(lfsr[19:18]), ACC_N, ACC_W),
                  make_val(int'(lfsr[13:12]), int'(lfsr[21:20]), PRD_N, PRD_W),
                  make_val(int'(lfsr[15:14]), int'(lfsr[23:22]), PRD_N, PRD_W),
                  "R6 random peak/load");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule